// File: doc/BRIEF.md
# Double-Buffered Serial DAC Code Register

This block is the digital front end of a 12-bit voltage-output converter. A host shifts a code in serially, most significant bit first. The shift clock only takes effect while the active-low select is low. A separate holding register drives the converter. It changes only through the active-low load strobe, so a new word can be staged without disturbing the present output.

The load strobe is level-sensitive. While it is low, the holding register tracks the shift register. An active-low asynchronous clear zeroes the holding register at once and wins over load. All serial inputs are sampled on the system clock `clk`, which must run faster than the serial clock. A rising edge of the serial clock is found by comparing two successive samples.

A sticky flag reports one misuse: a qualified shift edge while load is low. For checking, the block also reports the output level as a count of half-millivolts.

Top module: `dacFront`

## Requirements
- R1: On the first `clk` edge after `sclk` is seen rising with `csN` low, the shift register moves up one place and takes `sdi` into bit 0. Twelve such edges therefore load a word most significant bit first.
- R2: While `csN` is high, `sclk` edges leave the shift register unchanged.
- R3: A load strobe transfers the shift register whatever the level of `csN`.
- R4: While `loadN` is low, `dacCode` takes the shift register value at every `clk` edge. It therefore follows a shift register that changes during that time.
- R5: While `loadN` is high, `dacCode` holds its value through any serial clock and data activity.
- R6: While `clrN` is low, `dacCode` is zero with no clock edge needed, even when `loadN` is low.
- R7: If `clrN` returns high while `loadN` is high, `dacCode` stays zero. The clear leaves the shift register contents intact.
- R8: `levelHalfMv` equals the code in half-millivolt units: 0xFFF gives 4095 (2.0475 V), 0x800 gives 2048, 0x7FF gives 2047 and 0x000 gives 0.
- R9: A qualified shift edge (R1) while `loadN` is low sets `errFlag`. The flag stays set until a `clk` edge with `errClr` high clears it. A set in the same cycle wins over the clear, and edges with `csN` high never set it.
- R10: Synchronous `rst` high zeroes the shift register, the holding register and `errFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial inputs |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Select, active low; gates shifting only |
| sclk | input | 1 | Serial clock; its rising edge shifts |
| sdi | input | 1 | Serial data, most significant bit first |
| loadN | input | 1 | Level-sensitive load, active low |
| clrN | input | 1 | Asynchronous clear of the holding register, active low |
| errClr | input | 1 | Clears the misuse flag at a clock edge |
| dacCode | output | 12 | Code held for the converter |
| levelHalfMv | output | 13 | Output level in half-millivolt counts |
| errFlag | output | 1 | Sticky flag for shifting while loading |

## Verification
The properties assume that `clrN`, `loadN`, `csN`, `sclk` and `sdi` change only between `clk` edges. They also assume that `clrN` never pulses low and back high within a single clock period, because a sampled property cannot see such a pulse. The bench drives every input on the falling edge of `clk` and holds each `sclk` level and each clear or load level for at least two clock periods. Misuse is provoked deliberately in one scenario only, so that the transparency and flag requirements can be observed.

// File: rtl/dacFrontPkg.sv
package dacFrontPkg;
  typedef struct packed {
    logic shiftEn;  // qualified serial clock rising edge
    logic loadEn;   // holding register follows shift register
    logic errSet;   // shift attempted while load is active
  } dacStrobe_t;
endpackage

// File: rtl/dacCtrl.sv
module dacCtrl
  import dacFrontPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       csN,
  input  logic       sclk,
  input  logic       loadN,
  input  logic       errClr,
  output dacStrobe_t strobe,
  output logic       errFlag
);
  logic sclkPrev;
  logic sclkRise;

  // previous sample of the serial clock for edge detection
  always_ff @(posedge clk) begin
    if (rst) sclkPrev <= sclk;
    else     sclkPrev <= sclk;
  end

  assign sclkRise = sclk & ~sclkPrev;

  always_comb begin
    strobe.shiftEn = sclkRise & ~csN;
    strobe.loadEn  = ~loadN;
    strobe.errSet  = sclkRise & ~csN & ~loadN;
  end

  // sticky misuse flag; a new set outranks the clear request
  always_ff @(posedge clk) begin
    if (rst)                errFlag <= 1'b0;
    else if (strobe.errSet) errFlag <= 1'b1;
    else if (errClr)        errFlag <= 1'b0;
  end
endmodule

// File: rtl/dacPath.sv
module dacPath
  import dacFrontPkg::*;
#(
  parameter int W               = 12,
  parameter int HALF_MV_PER_LSB = 1,
  parameter int LVL_W           = W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clrN,
  input  logic             sdi,
  input  dacStrobe_t       strobe,
  output logic [W-1:0]     shiftWord,
  output logic [W-1:0]     holdWord,
  output logic [LVL_W-1:0] level
);
  // input shift register, most significant bit arrives first
  always_ff @(posedge clk) begin
    if (rst)                 shiftWord <= '0;
    else if (strobe.shiftEn) shiftWord <= {shiftWord[W-2:0], sdi};
  end

  // holding register: asynchronous clear outranks reset and load
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)              holdWord <= '0;
    else if (rst)           holdWord <= '0;
    else if (strobe.loadEn) holdWord <= shiftWord;
  end

  generate
    if (HALF_MV_PER_LSB == 1) begin : g_unitScale
      assign level = LVL_W'(holdWord);
    end else begin : g_scaled
      assign level = LVL_W'(holdWord) * LVL_W'(HALF_MV_PER_LSB);
    end
  endgenerate
endmodule

// File: rtl/dacFront.sv
module dacFront
  import dacFrontPkg::*;
#(
  parameter int W               = 12,
  parameter int HALF_MV_PER_LSB = 1,
  localparam int LVL_W          = W + $clog2(HALF_MV_PER_LSB + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csN,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             loadN,
  input  logic             clrN,
  input  logic             errClr,
  output logic [W-1:0]     dacCode,
  output logic [LVL_W-1:0] levelHalfMv,
  output logic             errFlag
);
  dacStrobe_t   strobe;
  logic [W-1:0] shiftWord;

  dacCtrl u_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .sclk(sclk), .loadN(loadN),
    .errClr(errClr), .strobe(strobe), .errFlag(errFlag)
  );

  dacPath #(.W(W), .HALF_MV_PER_LSB(HALF_MV_PER_LSB), .LVL_W(LVL_W)) u_path (
    .clk(clk), .rst(rst), .clrN(clrN), .sdi(sdi), .strobe(strobe),
    .shiftWord(shiftWord), .holdWord(dacCode), .level(levelHalfMv)
  );
endmodule

// File: rtl/dacFrontChk.sv
module dacFrontChk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         csN,
  input logic         loadN,
  input logic         clrN,
  input logic         errClr,
  input logic         errFlag,
  input logic [W-1:0] dacCode,
  input logic [W-1:0] shiftWord
);
  p_cs_blocks_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (csN && !rst) |=> $stable(shiftWord));

  p_load_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (!loadN && clrN && !rst) |=> (!clrN || dacCode == $past(shiftWord)));

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (loadN && clrN && !rst) |=> (!clrN || $stable(dacCode)));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !clrN |-> dacCode == '0);

  p_clear_persists_r7: assert property (@(posedge clk) disable iff (rst)
    !clrN |=> dacCode == '0);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (errFlag && !errClr) |=> errFlag);
endmodule

bind dacFront dacFrontChk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .csN(csN), .loadN(loadN), .clrN(clrN),
  .errClr(errClr), .errFlag(errFlag), .dacCode(dacCode), .shiftWord(shiftWord)
);

// File: tb/tb_dacFront.sv
module tb_dacFront;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        loadN = 1'b1;
  logic        clrN = 1'b1;
  logic        errClr = 1'b0;
  logic [11:0] dacCode;
  logic [12:0] levelHalfMv;
  logic        errFlag;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dacFront dut (
    .clk(clk), .rst(rst), .csN(csN), .sclk(sclk), .sdi(sdi), .loadN(loadN),
    .clrN(clrN), .errClr(errClr), .dacCode(dacCode),
    .levelHalfMv(levelHalfMv), .errFlag(errFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sdi = b; sclk = 1'b1; cyc(2);
    sclk = 1'b0; cyc(2);
  endtask

  task automatic shiftIn(input logic [11:0] w, input logic cs);
    csN = cs; cyc(1);
    for (int i = 11; i >= 0; i--) sendBit(w[i]);
    csN = 1'b1; cyc(1);
  endtask

  task automatic strobeLoad();
    loadN = 1'b0; cyc(2);
    loadN = 1'b1; cyc(1);
  endtask

  task automatic t_reset();
    chk("R10 reset code", dacCode, 0);
    chk("R10 reset level", levelHalfMv, 0);
    chk("R10 reset flag", errFlag, 0);
  endtask

  task automatic t_basic();
    shiftIn(12'hA5C, 1'b0);
    chk("R5 output held before load", dacCode, 0);
    strobeLoad();
    chk("R1 R4 loaded word", dacCode, 12'hA5C);
    chk("R9 no flag on clean load", errFlag, 0);
  endtask

  task automatic t_levels();
    shiftIn(12'hFFF, 1'b0); strobeLoad();
    chk("R8 full scale", levelHalfMv, 4095);
    shiftIn(12'h800, 1'b0); strobeLoad();
    chk("R8 midscale", levelHalfMv, 2048);
    shiftIn(12'h7FF, 1'b0); strobeLoad();
    chk("R8 below midscale", levelHalfMv, 2047);
    shiftIn(12'h000, 1'b0); strobeLoad();
    chk("R8 zero scale", levelHalfMv, 0);
  endtask

  task automatic t_select();
    shiftIn(12'h3C3, 1'b0);
    shiftIn(12'hFFF, 1'b1);
    chk("R5 hold through deselected clocking", dacCode, 0);
    csN = 1'b1;
    strobeLoad();
    chk("R2 R3 deselected clocks ignored, load with cs high", dacCode, 12'h3C3);
  endtask

  task automatic t_transparent();
    loadN = 1'b0; cyc(2);
    chk("R4 transparent start", dacCode, 12'h3C3);
    csN = 1'b1; sendBit(1'b0);
    chk("R9 no flag with cs high", errFlag, 0);
    chk("R2 no shift with cs high", dacCode, 12'h3C3);
    csN = 1'b0; cyc(1);
    sendBit(1'b1);
    csN = 1'b1; cyc(1);
    chk("R4 follows shift while load low", dacCode, 12'h787);
    chk("R9 flag set on shift during load", errFlag, 1);
    loadN = 1'b1; cyc(2);
    chk("R9 flag sticky", errFlag, 1);
    errClr = 1'b1; cyc(1);
    errClr = 1'b0; cyc(1);
    chk("R9 flag cleared", errFlag, 0);
  endtask

  task automatic t_clear();
    shiftIn(12'h5A1, 1'b0);
    strobeLoad();
    chk("R4 load before clear", dacCode, 12'h5A1);
    #1 clrN = 1'b0;
    #0.5 chk("R6 immediate clear", dacCode, 0);
    cyc(1);
    loadN = 1'b0; cyc(3);
    chk("R6 clear overrides load", dacCode, 0);
    loadN = 1'b1; cyc(2);
    clrN = 1'b1; cyc(3);
    chk("R7 zero kept after clear release", dacCode, 0);
    strobeLoad();
    chk("R7 shift register intact", dacCode, 12'h5A1);
  endtask

  task automatic t_syncReset();
    rst = 1'b1; cyc(2);
    rst = 1'b0; cyc(1);
    chk("R10 hold zeroed", dacCode, 0);
    strobeLoad();
    chk("R10 shift zeroed", dacCode, 0);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_basic();
    t_levels();
    t_select();
    t_transparent();
    t_clear();
    t_syncReset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule